// File: doc/BRIEF.md
# DMA Burst Sequencer for an AHB Master

The block turns one DMA transfer request into a stream of AHB master address beats. A transfer is given by a start byte address, a length in 32-bit words, a 4-bit burst-type code and a tail-mode bit. The block captures these on a start strobe. It then issues the beats one per accepted cycle, choosing each burst's type and length as the burst begins.

The code selects SINGLE, undefined-length INCR, or a fixed INCR4, INCR8 or INCR16 burst. A fixed burst is used only when enough words remain and it does not cross a 1 KB address boundary. Otherwise the words go out in tail mode: one INCR burst, or individual SINGLE beats when the tail-mode bit is set. Beats hold while HREADY is low. A one-cycle done pulse follows the final data phase.

A separate combinational lane swap reverses the byte order of descriptor read data when the invert bit is set.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, htrans is IDLE (2'b00) and done is 0.
- R2: For codes 4'b0011, 4'b0101 and 4'b0111, the block issues fixed bursts of 4, 8 and 16 beats with hburst 3'b011, 3'b101 and 3'b111. It does so whenever at least that many words remain and the burst stays inside the current 1 KB region.
- R3: Code 4'b0000, and every code other than 4'b0001, 4'b0011, 4'b0101 and 4'b0111, makes every beat a NONSEQ (2'b10) beat with hburst SINGLE (3'b000).
- R4: Code 4'b0001 sends the words as INCR bursts (hburst 3'b001). A new INCR burst starts only at a 1 KB boundary.
- R5: With a fixed code and singleTail=0, words that cannot form a whole fixed burst go out as one INCR burst. That burst runs up to the end of the transfer or the 1 KB boundary, whichever comes first.
- R6: With a fixed code and singleTail=1, those words go out as SINGLE beats.
- R7: No burst crosses a 1 KB boundary. A SEQ beat never carries an address whose low 10 bits are zero.
- R8: Each burst opens with a NONSEQ beat (2'b10) and continues with SEQ beats (2'b11). Each accepted beat advances haddr by 4, starting from the word-aligned start address.
- R9: While a beat is driven and hready is low, haddr, htrans and hburst hold their values.
- R10: done is high for exactly one cycle. It follows the cycle in which the final data phase completes with hready high. A zero-length transfer issues no beats and raises done in the cycle after start.
- R11: descOut equals descIn when descInvert is 0 and equals descIn with its byte order reversed when descInvert is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| startAddr | input | ADDR_W | Transfer start byte address |
| wordLen | input | LEN_W | Transfer length in 32-bit words |
| burstCode | input | 4 | Burst-type code |
| singleTail | input | 1 | 1: leftover words as SINGLE beats; 0: as INCR |
| hready | input | 1 | AHB ready |
| descInvert | input | 1 | Reverse descriptor byte order |
| descIn | input | DATA_W | Descriptor read data from the bus |
| htrans | output | 2 | AHB transfer type |
| hburst | output | 3 | AHB burst type |
| hsize | output | 3 | AHB transfer size (word) |
| haddr | output | ADDR_W | AHB address |
| done | output | 1 | Transfer complete pulse |
| descOut | output | DATA_W | Descriptor data after optional lane swap |

## Verification
The bench aims transfers just below a 1 KB boundary. A sequencer that checks only the remaining length would then emit a SEQ beat at the boundary address or a fixed burst that runs past it. Lengths one short of, equal to and longer than a fixed burst expose a wrong tail choice, such as INCR sent when SINGLE beats were asked for, or a fixed burst chosen with too few words left. Random HREADY low cycles, including one on the last data phase, catch addresses that advance while stalled and a done pulse that comes early or lasts two cycles. Reserved codes and a zero length catch stray fixed bursts and a hang with no done.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_INCR   = 3'b001;

  localparam logic [3:0] CODE_INCR   = 4'b0001;
  localparam logic [3:0] CODE_INCR4  = 4'b0011;
  localparam logic [3:0] CODE_INCR8  = 4'b0101;
  localparam logic [3:0] CODE_INCR16 = 4'b0111;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;
endpackage

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lenZero,
  input  logic       hready,
  input  logic       firstBeat,
  input  logic       lastBeat,
  output seqStrobe_t strobe,
  output logic [1:0] htrans,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateNext   = lenZero ? S_DONE : S_ADDR;
      end
      S_ADDR: if (hready) begin
        strobe.advance = 1'b1;
        if (lastBeat) stateNext = S_DATA;
      end
      S_DATA: if (hready) stateNext = S_DONE;
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    if (state == S_ADDR) htrans = firstBeat ? TR_NONSEQ : TR_SEQ;
    else                 htrans = TR_IDLE;
  end
  assign done = (state == S_DONE);

  // R10: the final data phase ends in done, never a return to address beats
  p_data_to_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && hready) |=> (state == S_DONE));
endmodule

// File: rtl/dma_burst_datapath.sv
module dma_burst_datapath
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 32,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic [3:0]        burstCode,
  input  logic              singleTail,
  input  logic              descInvert,
  input  logic [DATA_W-1:0] descIn,
  output logic [ADDR_W-1:0] haddr,
  output logic [2:0]        hburst,
  output logic              firstBeat,
  output logic              lastBeat,
  output logic [DATA_W-1:0] descOut
);
  localparam int BOUND_WORDS = BOUND_BYTES / 4;
  localparam int IDX_HI      = $clog2(BOUND_BYTES) - 1;
  localparam int BW_W        = $clog2(BOUND_WORDS) + 1;
  localparam int NBYTES      = DATA_W / 8;

  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  remaining, burstLeft, decLen, fixedLen, roomLen, toBoundL;
  logic [BW_W-1:0]   wordsToBound;
  logic [3:0]        codeReg;
  logic              tailReg;
  logic [2:0]        curType, decType;

  assign wordsToBound = BW_W'(BOUND_WORDS) - {1'b0, addrReg[IDX_HI:2]};

  always_comb begin
    toBoundL = LEN_W'(wordsToBound);
    roomLen  = (remaining < toBoundL) ? remaining : toBoundL;
    unique case (codeReg)
      CODE_INCR4:  fixedLen = LEN_W'(4);
      CODE_INCR8:  fixedLen = LEN_W'(8);
      CODE_INCR16: fixedLen = LEN_W'(16);
      default:     fixedLen = '0;
    endcase
    if (codeReg == CODE_INCR) begin
      decType = HB_INCR;
      decLen  = roomLen;
    end else if (fixedLen != '0 && remaining >= fixedLen && toBoundL >= fixedLen) begin
      decType = codeReg[2:0];
      decLen  = fixedLen;
    end else if (fixedLen != '0 && !tailReg) begin
      decType = HB_INCR;
      decLen  = roomLen;
    end else begin
      decType = HB_SINGLE;
      decLen  = LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      remaining <= '0;
      burstLeft <= '0;
      curType   <= HB_SINGLE;
      codeReg   <= '0;
      tailReg   <= 1'b0;
    end else if (strobe.load) begin
      addrReg   <= startAddr & ~ADDR_W'(3);
      remaining <= wordLen;
      burstLeft <= '0;
      curType   <= HB_SINGLE;
      codeReg   <= burstCode;
      tailReg   <= singleTail;
    end else if (strobe.advance) begin
      addrReg   <= addrReg + ADDR_W'(4);
      remaining <= remaining - LEN_W'(1);
      if (burstLeft == '0) begin
        burstLeft <= decLen - LEN_W'(1);
        curType   <= decType;
      end else begin
        burstLeft <= burstLeft - LEN_W'(1);
      end
    end
  end

  assign haddr     = addrReg;
  assign firstBeat = (burstLeft == '0);
  assign lastBeat  = (remaining == LEN_W'(1));
  assign hburst    = firstBeat ? decType : curType;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign descOut[b*8 +: 8] = descInvert ? descIn[(NBYTES-1-b)*8 +: 8] : descIn[b*8 +: 8];
  end

  // R7: a burst opened at a beat never extends past the region end
  p_len_fits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && firstBeat) |-> (decLen <= toBoundL && decLen != '0));
  // R8: every accepted beat consumes exactly one word
  p_rem_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (remaining == $past(remaining) - LEN_W'(1)));
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DATA_W      = 32,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic [3:0]        burstCode,
  input  logic              singleTail,
  input  logic              hready,
  input  logic              descInvert,
  input  logic [DATA_W-1:0] descIn,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic [ADDR_W-1:0] haddr,
  output logic              done,
  output logic [DATA_W-1:0] descOut
);
  localparam int BOUND_LSB = $clog2(BOUND_BYTES);

  seqStrobe_t strobe;
  logic       firstBeat, lastBeat;

  dma_burst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenZero(wordLen == '0),
    .hready(hready), .firstBeat(firstBeat), .lastBeat(lastBeat),
    .strobe(strobe), .htrans(htrans), .done(done)
  );

  dma_burst_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .BOUND_BYTES(BOUND_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .wordLen(wordLen), .burstCode(burstCode), .singleTail(singleTail),
    .descInvert(descInvert), .descIn(descIn), .haddr(haddr), .hburst(hburst),
    .firstBeat(firstBeat), .lastBeat(lastBeat), .descOut(descOut)
  );

  assign hsize = 3'b010;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (htrans != TR_IDLE && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hburst)));
  p_seq_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (htrans != TR_IDLE && hready) |=> (htrans != TR_SEQ || haddr == $past(haddr) + ADDR_W'(4)));
  p_no_cross_r7: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == TR_SEQ) |-> (haddr[BOUND_LSB-1:0] != '0));
  p_single_nonseq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (htrans != TR_IDLE && hburst == HB_SINGLE) |-> (htrans == TR_NONSEQ));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (htrans == TR_IDLE));
endmodule

// File: tb/tb_dma_burst_seq.sv
module tb_dma_burst_seq;
  logic        clk = 0, rstN = 0, start = 0, singleTail = 0, hready = 1, descInvert = 0;
  logic [31:0] startAddr = 0, descIn = 0;
  logic [15:0] wordLen = 0;
  logic [3:0]  burstCode = 0;
  logic [1:0]  htrans;
  logic [2:0]  hburst, hsize;
  logic [31:0] haddr, descOut;
  logic        done;

  int tests = 0, fails = 0, cycles = 0;
  bit reported = 0;

  logic [31:0] expAddr  [0:2047];
  logic [1:0]  expTrans [0:2047];
  logic [2:0]  expBurst [0:2047];
  int          expN;

  dma_burst_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .wordLen(wordLen),
    .burstCode(burstCode), .singleTail(singleTail), .hready(hready),
    .descInvert(descInvert), .descIn(descIn), .htrans(htrans), .hburst(hburst),
    .hsize(hsize), .haddr(haddr), .done(done), .descOut(descOut)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !reported) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not finish (act cycles=%0d exp <=150000)", cycles);
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Expected beat list computed from the requirements
  task automatic buildExp(input logic [31:0] a0, input int len, input logic [3:0] code, input bit tail);
    int rem, room, fl, blen;
    logic [31:0] a;
    logic [2:0] bt;
    rem = len; a = a0 & ~32'd3; expN = 0;
    while (rem > 0) begin
      room = 256 - int'(a[9:2]);
      fl = (code == 4'b0011) ? 4 : (code == 4'b0101) ? 8 : (code == 4'b0111) ? 16 : 0;
      if (code == 4'b0001) begin
        bt = 3'b001; blen = (rem < room) ? rem : room;
      end else if (fl != 0 && rem >= fl && room >= fl) begin
        bt = code[2:0]; blen = fl;
      end else if (fl != 0 && !tail) begin
        bt = 3'b001; blen = (rem < room) ? rem : room;
      end else begin
        bt = 3'b000; blen = 1;
      end
      for (int k = 0; k < blen; k++) begin
        expAddr[expN] = a; expTrans[expN] = (k == 0) ? 2'b10 : 2'b11; expBurst[expN] = bt;
        a += 4; rem--; expN++;
      end
    end
  endtask

  task automatic runXfer(input logic [31:0] a0, input int len, input logic [3:0] code,
                         input bit tail, input bit randReady, input string tag);
    int idx, iter;
    bit expDone, finished, prevHeld, hr;
    logic [31:0] heldAddr;
    buildExp(a0, len, code, tail);
    @(negedge clk);
    startAddr = a0; wordLen = 16'(len); burstCode = code; singleTail = tail; start = 1;
    hready = 1;
    @(negedge clk);
    start = 0;
    if (len == 0) begin
      check(done == 1'b1, "R10", "zero-length done", 64'(done), 64'd1);
      check(htrans == 2'b00, "R10", "zero-length no beat", 64'(htrans), 64'd0);
      @(negedge clk);
      check(done == 1'b0, "R10", "done width", 64'(done), 64'd0);
      return;
    end
    idx = 0; iter = 0; expDone = 0; finished = 0; prevHeld = 0; heldAddr = '0;
    while (!finished && iter < 8000) begin
      hr = randReady ? ($urandom % 4 != 0) : 1'b1;
      hready = hr;
      if (idx < expN) begin
        check(htrans == expTrans[idx] && haddr == expAddr[idx] && hburst == expBurst[idx],
              tag, $sformatf("beat %0d trans/addr/burst", idx),
              {29'd0, htrans, hburst, haddr}, {29'd0, expTrans[idx], expBurst[idx], expAddr[idx]});
      end else begin
        check(htrans == 2'b00, "R10", "idle after last beat", 64'(htrans), 64'd0);
      end
      if (prevHeld) check(haddr == heldAddr, "R9", "address held under wait", 64'(haddr), 64'(heldAddr));
      if (expDone) begin
        check(done == 1'b1, "R10", "done pulse", 64'(done), 64'd1);
        finished = 1;
      end else begin
        check(done == 1'b0, "R10", "no early done", 64'(done), 64'd0);
      end
      prevHeld = (idx < expN) && !hr;
      heldAddr = haddr;
      if (!finished) begin
        if (idx < expN) begin
          if (hr) idx++;
        end else if (hr) begin
          expDone = 1;
        end
      end
      @(negedge clk);
      iter++;
    end
    check(finished, tag, "transfer completed", 64'(finished), 64'd1);
    check(done == 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
    hready = 1;
  endtask

  initial begin
    logic [3:0] codes [0:6];
    codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0011; codes[3] = 4'b0101;
    codes[4] = 4'b0111; codes[5] = 4'b1010; codes[6] = 4'b0110;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(htrans == 2'b00, "R1", "reset htrans", 64'(htrans), 64'd0);
    check(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
    rstN = 1;
    @(negedge clk);
    check(htrans == 2'b00 && done == 1'b0, "R1", "idle after reset", 64'({htrans, done}), 64'd0);

    // R11 lane swap
    descIn = 32'h11223344; descInvert = 0; #1;
    check(descOut == 32'h11223344, "R11", "no swap", 64'(descOut), 64'h11223344);
    descInvert = 1; #1;
    check(descOut == 32'h44332211, "R11", "swap", 64'(descOut), 64'h44332211);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = $urandom; descIn = v; descInvert = 1; #1;
      check(descOut == {v[7:0], v[15:8], v[23:16], v[31:24]}, "R11", "random swap",
            64'(descOut), 64'({v[7:0], v[15:8], v[23:16], v[31:24]}));
    end
    descInvert = 0;

    // directed corners
    runXfer(32'h0000_1000, 0,  4'b0011, 0, 0, "R10");
    runXfer(32'h0000_2000, 5,  4'b0000, 0, 0, "R3");
    runXfer(32'h0000_2000, 6,  4'b1010, 0, 0, "R3");
    runXfer(32'h0000_23F8, 10, 4'b0001, 0, 0, "R4");
    runXfer(32'h0000_3000, 16, 4'b0101, 0, 0, "R2");
    runXfer(32'h0000_3000, 32, 4'b0111, 0, 1, "R2");
    runXfer(32'h0000_4000, 11, 4'b0011, 0, 0, "R5");
    runXfer(32'h0000_4000, 11, 4'b0011, 1, 0, "R6");
    runXfer(32'h0000_53E0, 40, 4'b0111, 0, 0, "R7");
    runXfer(32'h0000_53E0, 40, 4'b0111, 1, 1, "R7");
    runXfer(32'h0000_63F0, 20, 4'b0011, 0, 1, "R8");
    runXfer(32'h0000_7003, 9,  4'b0101, 0, 1, "R9");

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [31:0] a;
      a = $urandom;
      runXfer(a, int'($urandom % 70), codes[$urandom % 7], 1'($urandom), 1'b1, "R2");
    end

    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule